// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Unit

This block gathers a set of level-filtered external interrupt lines and one non-maskable line. It keeps a request flag, a polarity selection and a three-bit priority for each external line. It offers the processor two things: an acknowledge strobe that names the winning source, and a pending flag that is compared against the current processor priority. Every external line passes through a synchroniser and then a hold-time filter. The filter length is derived from the clock rate, so a minimum pulse width in nanoseconds is met whatever the clock. Edge detection runs after the polarity inversion, so flipping a line's polarity while the line is steady can itself raise a request.

The non-maskable line has no enable and cannot be turned off. A falling edge on it latches a request that outranks every maskable source. While the line is low, the stop-mode enable is held at zero, so a clock-stop request is refused. Wait and stop are modelled only as a small power state. That state gates a CPU clock enable and an oscillator-running flag, and any pending interrupt returns it to run.

Register access uses a synchronous write strobe and a combinational read. Addresses 0 to NUM_SRC-1 are the per-source control words. Address NUM_SRC is the mode word, and address NUM_SRC+1 is the port word.

Top module: `intr_unit`

## Requirements
- R1: An acknowledge reports the source with the highest nonzero level that has its request bit set. Equal levels go to the lower source number. A source whose level field is 0 never wins. When nothing qualifies, ackValid is 0.
- R2: Asserting ackRd clears the request bit of the reported maskable winner on that clock edge. The request bits of the other sources are unchanged.
- R3: A falling edge on nmiPin latches a non-maskable request. The request needs no enable. It is reported with number 2**NUM_W-1 (7 by default) and level 7, and it beats every maskable source. The next acknowledge clears it.
- R4: While nmiPin reads low, the stop-enable bit (bit 0 of the mode word) reads 0, and a write of 1 to it has no effect. While nmiPin is high, the written value is kept.
- R5: A change on an external line takes effect only after the new level has held for ceil(MIN_NS*CLK_MHZ/1000) clocks after synchronisation. A shorter pulse sets no request.
- R6: A request bit is set when the line level XOR its polarity bit (bit 3 of its control word) goes from 0 to 1. With polarity 0 this is a rising pin edge. Changing the polarity bit from 0 to 1 on a low line sets a request.
- R7: In a control word, writing 0 to bit 7 clears the request, and writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear. Bits 2:0 hold the level.
- R8: irqPending is 1 when the non-maskable request is latched, or when the winning maskable level is greater than cpuIpl.
- R9: waitReq drops cpuClkEn and keeps oscRun at 1. stopReq with stop-enable set drops both. stopReq with stop-enable clear is ignored. Any irqPending returns both outputs to 1 on the next clock.
- R10: Bit 0 of the port word reads the synchronised level of nmiPin.
- R11: After reset the control words, the mode word and ackValid are 0, irqPending is 0, and cpuClkEn and oscRun are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| intPin | input | NUM_SRC | External interrupt lines |
| nmiPin | input | 1 | Non-maskable interrupt line, active low |
| regAddr | input | ADDR_W | Register address |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| ackRd | input | 1 | Acknowledge strobe |
| ackValid | output | 1 | A source is reported |
| ackNum | output | NUM_W | Number of the winning source |
| ackLvl | output | LVL_W | Level of the winning source |
| cpuIpl | input | LVL_W | Current processor priority level |
| irqPending | output | 1 | Interrupt pending toward the processor |
| waitReq | input | 1 | Wait-mode request |
| stopReq | input | 1 | Stop-mode request |
| cpuClkEn | output | 1 | CPU clock enable |
| oscRun | output | 1 | Oscillator-running flag |

## Verification
The assertions assume that ackRd, regWr, waitReq and stopReq are single-cycle strobes driven between clock edges. They also assume that the external lines are low at reset, so the first filtered level does not look like an edge. The stimulus follows both rules. It holds every intended pin level well past the filter length and keeps each glitch far below it. Register writes that set up levels are issued before any line is raised, so that a write of 0 to bit 7 does not wipe a request the bench expects.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             srcWr;
    logic [SEL_W-1:0] srcSel;
    logic             ackClr;
    logic             nmiFall;
  } ctrl_strobe_t;

  typedef enum logic [1:0] {PWR_RUN, PWR_WAIT, PWR_STOP} pwr_state_t;
endpackage

// File: rtl/intr_filter.sv
module intr_filter #(
  parameter int HOLD_CYC = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic filtLvl
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(HOLD_CYC - 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      cnt <= '0;
      filtLvl <= 1'b0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (syncB == filtLvl) begin
        cnt <= '0;
      end else if (cnt == LIM) begin
        filtLvl <= syncB;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: the filtered level moves only after a full hold window
  p_filter_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLvl) |-> $past(cnt) == LIM);
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              wrBit0,
  input  logic              ackRd,
  input  logic              waitReq,
  input  logic              stopReq,
  input  logic              irqPending,
  output ctrl_strobe_t      strb,
  output logic [7:0]        ctrlRdata,
  output logic              cpuClkEn,
  output logic              oscRun
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(NUM_SRC + 1);

  logic nmiS1, nmiS2, nmiPrev, stopEn;
  pwr_state_t pwr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiS1 <= 1'b1;
      nmiS2 <= 1'b1;
      nmiPrev <= 1'b1;
    end else begin
      nmiS1 <= nmiPin;
      nmiS2 <= nmiS1;
      nmiPrev <= nmiS2;
    end
  end

  always_comb begin
    strb.srcWr = regWr && (int'(regAddr) < NUM_SRC);
    strb.srcSel = SEL_W'(regAddr);
    strb.ackClr = ackRd;
    strb.nmiFall = nmiPrev && !nmiS2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopEn <= 1'b0;
    else if (!nmiS2) stopEn <= 1'b0;
    else if (regWr && regAddr == MODE_ADDR) stopEn <= wrBit0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwr <= PWR_RUN;
    end else begin
      case (pwr)
        PWR_RUN: begin
          if (stopReq && stopEn) pwr <= PWR_STOP;
          else if (waitReq) pwr <= PWR_WAIT;
        end
        default: if (irqPending) pwr <= PWR_RUN;
      endcase
    end
  end

  assign cpuClkEn = (pwr == PWR_RUN);
  assign oscRun = (pwr != PWR_STOP);

  always_comb begin
    ctrlRdata = 8'h00;
    if (regAddr == MODE_ADDR) ctrlRdata[0] = stopEn;
    else if (regAddr == PORT_ADDR) ctrlRdata[0] = nmiS2;
  end

  // R4: a low non-maskable line forces the stop enable off
  p_stop_blocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    !nmiS2 |=> !stopEn);
  // R9: a stop request without the enable leaves the clock running
  p_stop_refused_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && stopReq && !waitReq && !stopEn) |=> cpuClkEn);
  // R9: wait keeps the oscillator alive
  p_wait_osc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && waitReq && !stopReq) |=> oscRun);
endmodule

// File: rtl/intr_dpath.sv
module intr_dpath
  import intr_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int LVL_W = 3,
  parameter int NUM_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] filtLvl,
  input  ctrl_strobe_t       strb,
  input  logic [7:0]         wdata,
  input  logic [ADDR_W-1:0]  rdSel,
  input  logic [LVL_W-1:0]   cpuIpl,
  output logic [7:0]         srcRdata,
  output logic               ackValid,
  output logic [NUM_W-1:0]   ackNum,
  output logic [LVL_W-1:0]   ackLvl,
  output logic               irqPending
);
  localparam logic [NUM_W-1:0] NMI_NUM = '1;
  localparam logic [LVL_W-1:0] NMI_LVL = '1;

  logic [NUM_SRC-1:0] reqR, polR, prevX, xVec, setVec;
  logic [LVL_W-1:0]   lvlR [NUM_SRC];
  logic               nmiLatch, found;
  logic [NUM_W-1:0]   bestIdx;
  logic [LVL_W-1:0]   bestLvl;

  assign xVec = filtLvl ^ polR;
  assign setVec = xVec & ~prevX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevX <= '0;
    else prevX <= xVec;
  end

  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqR[i] && lvlR[i] > bestLvl) begin
        bestLvl = lvlR[i];
        bestIdx = NUM_W'(i);
      end
    end
    found = (bestLvl != '0);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic selWr, wrClr, ackHit;
    assign selWr = strb.srcWr && (int'(strb.srcSel) == g);
    assign wrClr = selWr && !wdata[7];
    assign ackHit = strb.ackClr && !nmiLatch && found && (int'(bestIdx) == g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqR[g] <= 1'b0;
        polR[g] <= 1'b0;
        lvlR[g] <= '0;
      end else begin
        reqR[g] <= (reqR[g] && !(wrClr || ackHit)) || setVec[g];
        if (selWr) begin
          polR[g] <= wdata[3];
          lvlR[g] <= wdata[LVL_W-1:0];
        end
      end
    end

    // R7: a hardware set is never lost to a clear in the same cycle
    p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
      setVec[g] |=> reqR[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiLatch <= 1'b0;
    else nmiLatch <= strb.nmiFall || (nmiLatch && !strb.ackClr);
  end

  assign ackValid = nmiLatch || found;
  assign ackNum = nmiLatch ? NMI_NUM : bestIdx;
  assign ackLvl = nmiLatch ? NMI_LVL : bestLvl;
  assign irqPending = nmiLatch || (found && bestLvl > cpuIpl);

  always_comb begin
    srcRdata = 8'h00;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(rdSel) == i) begin
        srcRdata[7] = reqR[i];
        srcRdata[3] = polR[i];
        srcRdata[LVL_W-1:0] = lvlR[i];
      end
    end
  end

  // R2: the acknowledged maskable winner loses its request
  p_ack_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackClr && !nmiLatch && found && !setVec[bestIdx]) |=> !reqR[$past(bestIdx)]);
  // R3: the non-maskable request survives until acknowledged
  p_nmi_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (nmiLatch && !strb.ackClr) |=> nmiLatch);
endmodule

// File: rtl/intr_unit.sv
module intr_unit
  import intr_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int LVL_W = 3,
  parameter int CLK_MHZ = 200,
  parameter int MIN_NS = 250,
  parameter int NUM_W = $clog2(NUM_SRC + 1),
  parameter int ADDR_W = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] intPin,
  input  logic               nmiPin,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  input  logic               ackRd,
  output logic               ackValid,
  output logic [NUM_W-1:0]   ackNum,
  output logic [LVL_W-1:0]   ackLvl,
  input  logic [LVL_W-1:0]   cpuIpl,
  output logic               irqPending,
  input  logic               waitReq,
  input  logic               stopReq,
  output logic               cpuClkEn,
  output logic               oscRun
);
  localparam int RAW_CYC = (MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int FILT_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  logic [NUM_SRC-1:0] filtLvl;
  logic [7:0] srcRdata, ctrlRdata;
  ctrl_strobe_t strb;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_filt
    intr_filter #(.HOLD_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rstN(rstN), .pinIn(intPin[g]), .filtLvl(filtLvl[g]));
  end

  intr_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .regAddr(regAddr),
    .regWr(regWr), .wrBit0(regWdata[0]), .ackRd(ackRd),
    .waitReq(waitReq), .stopReq(stopReq), .irqPending(irqPending),
    .strb(strb), .ctrlRdata(ctrlRdata), .cpuClkEn(cpuClkEn), .oscRun(oscRun));

  intr_dpath #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .NUM_W(NUM_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .filtLvl(filtLvl), .strb(strb), .wdata(regWdata),
    .rdSel(regAddr), .cpuIpl(cpuIpl), .srcRdata(srcRdata), .ackValid(ackValid),
    .ackNum(ackNum), .ackLvl(ackLvl), .irqPending(irqPending));

  assign regRdata = (int'(regAddr) < NUM_SRC) ? srcRdata : ctrlRdata;

  // R8: a reported non-maskable request always shows as pending
  p_nmi_pend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackNum == '1) |-> irqPending);
endmodule

// File: tb/intr_unit_bench.sv
module intr_unit_bench;
  localparam int FILT = 50;

  logic clk = 0, rstN = 0;
  logic [5:0] intPin = '0;
  logic nmiPin = 1;
  logic [2:0] regAddr = '0;
  logic regWr = 0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic ackRd = 0, ackValid, irqPending, waitReq = 0, stopReq = 0, cpuClkEn, oscRun;
  logic [2:0] ackNum, ackLvl;
  logic [2:0] cpuIpl = 3'd7;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic v; logic [2:0] n; logic [2:0] l; string tag; } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  intr_unit u_intr_unit (
    .clk(clk), .rstN(rstN), .intPin(intPin), .nmiPin(nmiPin), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .ackRd(ackRd),
    .ackValid(ackValid), .ackNum(ackNum), .ackLvl(ackLvl), .cpuIpl(cpuIpl),
    .irqPending(irqPending), .waitReq(waitReq), .stopReq(stopReq),
    .cpuClkEn(cpuClkEn), .oscRun(oscRun));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rdChk(string tag, logic [2:0] a, logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 check(tag, regRdata, exp);
  endtask

  task automatic ack(string tag, logic v, logic [2:0] n, logic [2:0] l);
    exp_t e;
    e.v = v; e.n = n; e.l = l; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    ackRd = 1;
    @(negedge clk);
    ackRd = 0;
  endtask

  // monitor: pops expected acknowledge results as the design presents them
  initial forever begin
    @(negedge clk);
    #1;
    if (ackRd) begin
      exp_t e;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual %0h expected item", ackNum);
      end else begin
        e = expQ.pop_front();
        check({e.tag, " valid"}, ackValid, e.v);
        if (e.v) begin
          check({e.tag, " num"}, ackNum, e.n);
          check({e.tag, " lvl"}, ackLvl, e.l);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1;
    cyc(2);
    // R11 reset state
    rdChk("R11 src0", 3'd0, 8'h00);
    rdChk("R11 src5", 3'd5, 8'h00);
    rdChk("R11 mode", 3'd6, 8'h00);
    check("R11 ackValid", ackValid, 0);
    check("R11 pending", irqPending, 0);
    check("R11 clk/osc", {cpuClkEn, oscRun}, 2'b11);
    // R10 port reads high line
    rdChk("R10 port high", 3'd7, 8'h01);

    // set levels before raising lines
    wr(3'd1, 8'h05); wr(3'd2, 8'h03); wr(3'd4, 8'h05); wr(3'd0, 8'h00);
    wr(3'd5, 8'h04);
    intPin[0] = 1; intPin[1] = 1; intPin[2] = 1; intPin[4] = 1;
    cyc(FILT + 6);
    rdChk("R6 rising edge sets src0", 3'd0, 8'h80);
    // R1 tie on level 5 goes to lower number
    ack("R1 tie", 1, 3'd1, 3'd5);
    rdChk("R2 winner cleared", 3'd1, 8'h05);
    rdChk("R2 other kept", 3'd4, 8'h85);
    ack("R1 second", 1, 3'd4, 3'd5);
    ack("R1 third", 1, 3'd2, 3'd3);
    ack("R1 level0 never wins", 0, 3'd0, 3'd0);
    // R7 write 0 clears, write 1 keeps
    wr(3'd0, 8'h00);
    rdChk("R7 clear", 3'd0, 8'h00);
    wr(3'd3, 8'h80);
    rdChk("R7 write1 no set", 3'd3, 8'h00);

    // R8 pending threshold
    intPin[5] = 1;
    cyc(FILT + 6);
    cpuIpl = 3'd4;
    cyc(1);
    check("R8 level equal ipl", irqPending, 0);
    cpuIpl = 3'd3;
    cyc(1);
    check("R8 level above ipl", irqPending, 1);
    cpuIpl = 3'd7;

    // R9 wait then wake
    @(negedge clk); waitReq = 1; @(negedge clk); waitReq = 0;
    check("R9 wait clk/osc", {cpuClkEn, oscRun}, 2'b01);
    cpuIpl = 3'd0; cyc(1);
    check("R9 wake from wait", {cpuClkEn, oscRun}, 2'b11);
    cpuIpl = 3'd7;
    wr(3'd6, 8'h01);
    rdChk("R4 stop enable kept", 3'd6, 8'h01);
    @(negedge clk); stopReq = 1; @(negedge clk); stopReq = 0;
    check("R9 stop clk/osc", {cpuClkEn, oscRun}, 2'b00);
    cpuIpl = 3'd0; cyc(1);
    check("R9 wake from stop", {cpuClkEn, oscRun}, 2'b11);
    cpuIpl = 3'd7;
    wr(3'd6, 8'h00);
    @(negedge clk); stopReq = 1; @(negedge clk); stopReq = 0;
    check("R9 stop refused", {cpuClkEn, oscRun}, 2'b11);

    // R3 non-maskable
    nmiPin = 0;
    cyc(5);
    rdChk("R10 port low", 3'd7, 8'h00);
    check("R3 pending at max ipl", irqPending, 1);
    wr(3'd6, 8'h01);
    rdChk("R4 write ignored while low", 3'd6, 8'h00);
    @(negedge clk); stopReq = 1; @(negedge clk); stopReq = 0;
    check("R4 stop refused while low", {cpuClkEn, oscRun}, 2'b11);
    ack("R3 outranks src5", 1, 3'd7, 3'd7);
    cyc(1);
    check("R3 cleared by ack", irqPending, 0);
    nmiPin = 1;
    cyc(5);
    ack("R2 src5 after nmi", 1, 3'd5, 3'd4);

    // R5 short glitch rejected
    intPin[3] = 1; cyc(10); intPin[3] = 0;
    cyc(FILT + 6);
    rdChk("R5 glitch ignored", 3'd3, 8'h00);
    // R6 polarity flip on steady low line
    wr(3'd3, 8'h88);
    cyc(1);
    rdChk("R6 polarity flip sets", 3'd3, 8'h88);
    wr(3'd3, 8'h00);
    cyc(1);
    rdChk("R6 flip back no set", 3'd3, 8'h00);

    cyc(4);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual %0d expected 0", expQ.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule